// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

A single-digit synchronous decade counter that steps through the codes 0 to 9 in either direction. A direction select chooses increment or decrement, an active-low enable gates counting, and every change of count occurs on the rising clock edge. An active-low load strobe overrides everything else: while it is low the output takes the preset value at once, without waiting for a clock.

Two cascade outputs are provided. The terminal-count flag is a combinational decode that marks the last code before a wrap in the selected direction: 9 going up, 0 going down. A faster downstream stage can use it for look-ahead carry. The active-low ripple strobe pulses low during the low half of the clock while the flag is set and counting is enabled. Its rising edge falls at the next rising clock edge, so it can clock the next digit directly.

The six codes above 9 can appear after a preset or at power-up. Each of them has a defined successor in both directions, and the counter returns to the legal range within two counts.

Top module: `bcd_updown_counter`

## Requirements
- R1: While `load_n` is 0, `cnt_q` equals `pre_val` immediately, with no clock edge needed, whatever the values of `cnt_en_n` and `dir_dn`. After `load_n` returns to 1, counting continues from the `pre_val` value that was held at the last clock edge.
- R2: With `load_n`=1, `cnt_en_n`=0 and `dir_dn`=0, each rising clock edge raises a legal code 0..8 by one.
- R3: With `load_n`=1, `cnt_en_n`=0 and `dir_dn`=1, each rising clock edge lowers a legal code 1..9 by one.
- R4: With `load_n`=1 and `cnt_en_n`=1, `cnt_q` keeps its value across clock edges.
- R5: When counting, the code wraps from 9 to 0 going up (`dir_dn`=0) and from 0 to 9 going down (`dir_dn`=1).
- R6: `term_cnt` is 1 exactly when `cnt_q`=9 with `dir_dn`=0, or `cnt_q`=0 with `dir_dn`=1. It follows a change of `dir_dn` without a clock edge, and it is 0 for codes 10..15. While counting in a steady direction it is high for one cycle only.
- R7: `ripple_clk_n` is 0 only while `term_cnt`=1, `cnt_en_n`=0 and `clk`=0. At all other times it is 1.
- R8: The up-count successors of the illegal codes are 10→11, 11→4, 12→13, 13→4, 14→15 and 15→2.
- R9: The down-count successors of the illegal codes are 10→1, 11→10, 12→3, 13→12, 14→5 and 15→14.
- R10: Any code from 10 to 15, counted twice in one direction, gives a code from 0 to 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge active |
| load_n | input | 1 | Active-low asynchronous preset strobe |
| pre_val | input | 4 | Preset value |
| cnt_en_n | input | 1 | Active-low count enable |
| dir_dn | input | 1 | Direction: 0 counts up, 1 counts down |
| cnt_q | output | 4 | Current BCD count |
| term_cnt | output | 1 | Terminal-count flag for look-ahead cascading |
| ripple_clk_n | output | 1 | Active-low ripple strobe, clocks the next stage |

## Verification
The bench builds the counter with the package defaults: a 4-bit digit and a terminal value of 9. This puts all sixteen codes within reach. Every code from 10 to 15 is preset and counted twice in each direction, which covers the complete successor tables and the exit from the illegal codes. The bench also loads values mid-cycle, between clock edges, and samples the ripple strobe in both clock phases, so the asynchronous preset and the half-cycle strobe are checked in time as well as in value.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int DIGIT_W   = 4;
  localparam int LAST_CODE = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t TOP_CODE  = digit_t'(LAST_CODE);
  localparam digit_t ZERO_CODE = '0;
endpackage

// File: rtl/bcd_next_state.sv
`timescale 1ns/1ps
module bcd_next_state
  import bcd_pkg::*;
(
  input  digit_t cur,
  input  logic   dn,
  output digit_t nxt
);
  always_comb begin
    nxt = cur;
    if (!dn) begin
      unique case (cur)
        TOP_CODE:                nxt = ZERO_CODE;
        digit_t'(10):            nxt = digit_t'(11);
        digit_t'(11):            nxt = digit_t'(4);
        digit_t'(12):            nxt = digit_t'(13);
        digit_t'(13):            nxt = digit_t'(4);
        digit_t'(14):            nxt = digit_t'(15);
        digit_t'(15):            nxt = digit_t'(2);
        default:                 nxt = cur + digit_t'(1);
      endcase
    end else begin
      unique case (cur)
        ZERO_CODE:               nxt = TOP_CODE;
        digit_t'(10):            nxt = digit_t'(1);
        digit_t'(11):            nxt = digit_t'(10);
        digit_t'(12):            nxt = digit_t'(3);
        digit_t'(13):            nxt = digit_t'(12);
        digit_t'(14):            nxt = digit_t'(5);
        digit_t'(15):            nxt = digit_t'(14);
        default:                 nxt = cur - digit_t'(1);
      endcase
    end
  end
endmodule

// File: rtl/bcd_term_decode.sv
`timescale 1ns/1ps
module bcd_term_decode
  import bcd_pkg::*;
(
  input  logic   clk,
  input  digit_t cur,
  input  logic   dn,
  input  logic   en_n,
  output logic   tc,
  output logic   rc_n
);
  logic at_top, at_bottom;

  always_comb begin
    at_top    = (cur == TOP_CODE);
    at_bottom = (cur == ZERO_CODE);
    tc        = dn ? at_bottom : at_top;
    // strobe low only in the low clock phase of an enabled terminal cycle
    rc_n      = ~(tc & ~en_n & ~clk);
  end
endmodule

// File: rtl/bcd_updown_counter.sv
`timescale 1ns/1ps
module bcd_updown_counter
  import bcd_pkg::*;
(
  input  logic               clk,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] pre_val,
  input  logic               cnt_en_n,
  input  logic               dir_dn,
  output logic [DIGIT_W-1:0] cnt_q,
  output logic               term_cnt,
  output logic               ripple_clk_n
);
  digit_t cnt_r;
  digit_t cnt_step;
  digit_t cnt_d;

  bcd_next_state u_next (
    .cur (cnt_r),
    .dn  (dir_dn),
    .nxt (cnt_step)
  );

  // next-state: explicit clock enable
  always_comb begin
    cnt_d = cnt_r;
    if (!cnt_en_n) cnt_d = cnt_step;
  end

  // register: the preset strobe acts as the asynchronous set/clear path
  always_ff @(posedge clk or negedge load_n) begin
    if (!load_n) cnt_r <= pre_val;
    else         cnt_r <= cnt_d;
  end

  // preset is transparent while the strobe is held low
  always_comb cnt_q = load_n ? cnt_r : pre_val;

  bcd_term_decode u_term (
    .clk  (clk),
    .cur  (cnt_q),
    .dn   (dir_dn),
    .en_n (cnt_en_n),
    .tc   (term_cnt),
    .rc_n (ripple_clk_n)
  );
endmodule

// File: rtl/bcd_updown_counter_chk.sv
`timescale 1ns/1ps
module bcd_updown_counter_chk (
  input logic       clk,
  input logic       load_n,
  input logic       cnt_en_n,
  input logic       dir_dn,
  input logic [3:0] cnt_q,
  input logic       term_cnt
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |=> $stable(cnt_q));

  p_up_step_r2: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_dn && cnt_q < 4'd9) |=> (cnt_q == $past(cnt_q) + 4'd1));

  p_down_step_r3: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_dn && cnt_q > 4'd0 && cnt_q <= 4'd9) |=> (cnt_q == $past(cnt_q) - 4'd1));

  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !dir_dn && cnt_q == 4'd9) |=> (cnt_q == 4'd0));

  p_wrap_down_r5: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && dir_dn && cnt_q == 4'd0) |=> (cnt_q == 4'd9));

  p_tc_single_r6: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && term_cnt) ##1 $stable(dir_dn) |-> !term_cnt);

  p_illegal_exit_r10: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && cnt_q > 4'd9) ##1 (!cnt_en_n && cnt_q > 4'd9 && $stable(dir_dn))
    |=> (cnt_q <= 4'd9));
endmodule

bind bcd_updown_counter bcd_updown_counter_chk chk_i (
  .clk      (clk),
  .load_n   (load_n),
  .cnt_en_n (cnt_en_n),
  .dir_dn   (dir_dn),
  .cnt_q    (cnt_q),
  .term_cnt (term_cnt)
);

// File: tb/bcd_updown_counter_tb_top.sv
`timescale 1ns/1ps
module bcd_updown_counter_tb_top;
  logic       clk;
  logic       load_n;
  logic [3:0] pre_val;
  logic       cnt_en_n;
  logic       dir_dn;
  logic [3:0] cnt_q;
  logic       term_cnt;
  logic       ripple_clk_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  bcd_updown_counter dut_i (
    .clk(clk), .load_n(load_n), .pre_val(pre_val), .cnt_en_n(cnt_en_n),
    .dir_dn(dir_dn), .cnt_q(cnt_q), .term_cnt(term_cnt), .ripple_clk_n(ripple_clk_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // successor from the requirement tables
  function automatic int ref_next(input int v, input bit dn);
    if (!dn) begin
      case (v)
        9: return 0;  10: return 11; 11: return 4;
        12: return 13; 13: return 4; 14: return 15; 15: return 2;
        default: return v + 1;
      endcase
    end else begin
      case (v)
        0: return 9;  10: return 1;  11: return 10;
        12: return 3; 13: return 12; 14: return 5; 15: return 14;
        default: return v - 1;
      endcase
    end
  endfunction

  function automatic int ref_tc(input int v, input bit dn);
    return ((!dn && v == 9) || (dn && v == 0)) ? 1 : 0;
  endfunction

  // move to 1 ns after the next rising edge
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic preset(input int v);
    pre_val = 4'(v); load_n = 1'b0;
    #0.5 chk("R1 preset visible", cnt_q, v);
    tick();
    load_n = 1'b1;
    #0.2 chk("R1 value kept after release", cnt_q, v);
  endtask

  task automatic t_reset_state();
    chk("R1 start preset", cnt_q, 0);
    chk("R6 start tc", term_cnt, 0);
    chk("R7 start rc", ripple_clk_n, 1);
  endtask

  task automatic t_async_load();
    tick();
    cnt_en_n = 1'b0; dir_dn = 1'b0;
    preset(2);
    tick();
    chk("R2 count from preset", cnt_q, 3);
    #0.5 pre_val = 4'd7; load_n = 1'b0;
    #0.3 chk("R1 async load mid cycle", cnt_q, 7);
    pre_val = 4'd6;
    #0.3 chk("R1 follows preset while low", cnt_q, 6);
    tick();
    chk("R1 load beats clock", cnt_q, 6);
    load_n = 1'b1;
    tick();
    chk("R1 resume from preset", cnt_q, 7);
  endtask

  task automatic t_count(input bit dn, input int start, input int steps);
    int exp;
    exp = start;
    dir_dn = dn; cnt_en_n = 1'b0;
    preset(start);
    for (int i = 0; i < steps; i++) begin
      tick();
      exp = ref_next(exp, dn);
      chk(dn ? "R3 R5 down count" : "R2 R5 up count", cnt_q, exp);
      chk("R6 tc decode", term_cnt, ref_tc(exp, dn));
    end
  endtask

  task automatic t_hold();
    dir_dn = 1'b0; cnt_en_n = 1'b0;
    preset(9);
    cnt_en_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 hold", cnt_q, 9);
    end
    chk("R6 tc while held", term_cnt, 1);
    dir_dn = 1'b1;
    tick();
    chk("R4 hold down", cnt_q, 9);
  endtask

  task automatic t_tc_rc();
    dir_dn = 1'b0; cnt_en_n = 1'b0;
    preset(9);
    // now 0.2 ns past the release; next edge is ~2.8 ns away, clk high until +1.0
    chk("R6 tc at 9 up", term_cnt, 1);
    chk("R7 rc high in high phase", ripple_clk_n, 1);
    @(negedge clk); #0.5;
    chk("R7 rc low in low phase", ripple_clk_n, 0);
    cnt_en_n = 1'b1;
    #0.2 chk("R7 rc high when disabled", ripple_clk_n, 1);
    dir_dn = 1'b1;
    #0.2 chk("R6 tc follows direction", term_cnt, 0);
    cnt_en_n = 1'b0;
    #0.2 chk("R7 rc high without tc", ripple_clk_n, 1);
    dir_dn = 1'b0;
    tick();
    chk("R5 wrap to 0", cnt_q, 0);
    chk("R6 tc drops after wrap", term_cnt, 0);
    @(negedge clk); #0.5;
    chk("R7 rc high after wrap", ripple_clk_n, 1);
    tick();
    dir_dn = 1'b1; cnt_en_n = 1'b0;
    preset(0);
    chk("R6 tc at 0 down", term_cnt, 1);
    @(negedge clk); #0.5;
    chk("R7 rc low at 0 down", ripple_clk_n, 0);
  endtask

  task automatic t_illegal(input bit dn);
    int e1, e2;
    for (int v = 10; v < 16; v++) begin
      dir_dn = dn; cnt_en_n = 1'b0;
      preset(v);
      chk("R6 tc low on illegal", term_cnt, 0);
      tick();
      e1 = ref_next(v, dn);
      chk(dn ? "R9 illegal down" : "R8 illegal up", cnt_q, e1);
      tick();
      e2 = ref_next(e1, dn);
      chk("R10 legal within two counts", (cnt_q <= 4'd9) ? 1 : 0, 1);
      chk("R10 second step", cnt_q, e2);
    end
  endtask

  initial begin
    load_n = 1'b0; pre_val = 4'd0; cnt_en_n = 1'b1; dir_dn = 1'b0;
    #1;
    t_reset_state();
    t_async_load();
    t_count(1'b0, 0, 12);
    t_count(1'b1, 3, 12);
    t_hold();
    t_tc_rc();
    t_illegal(1'b0);
    t_illegal(1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule